// File: doc/BRIEF.md
# Paged Pointer Step Unit

This block moves a 24-bit pointer forward or backward by a small unsigned step. The pointer is held as two fields: a 16-bit offset within a page and an 8-bit page byte above it. The step is added to or subtracted from the offset first. The carry or borrow from that operation then ripples into the page byte one clock later.

Status flags are produced along the way and written into the status register as a side effect. The flags describe the 16-bit offset operation alone, not the 24-bit pointer. The page step reads its carry from that registered status, so every update rewrites all four flags whether or not the caller wanted them. Code that branches on flags set before a pointer step therefore sees the step's flags instead.

A caller presents the current page and offset, the step size and the direction, and pulses a start strobe. The new offset and flags appear on the outputs one cycle later, marked by a flag-write strobe. The new page appears one cycle after that, marked by a done pulse.

Top module: `ptr_step_unit`

## Requirements
- R1: While reset is high, the offset, page, the four flags, the flag-write strobe and the done pulse are all zero.
- R2: An increment accepted at a clock edge puts (offset + step) mod 65536 on the offset output after that edge, with the flag-write strobe high for exactly that one cycle.
- R3: A decrement (direction input high) accepted at a clock edge puts (offset − step) mod 65536 on the offset output after that edge, with the flag-write strobe high for that one cycle.
- R4: The carry flag is the carry out of bit 15 on an increment. On a decrement it is the no-borrow indication: 1 when offset ≥ step, 0 when a borrow occurred.
- R5: The zero flag is 1 exactly when the new 16-bit offset is 0x0000, even if the page is nonzero. The negative flag equals bit 15 of the new offset.
- R6: The overflow flag is 1 when the 16-bit offset operation overflows as a signed two's-complement operation. With a positive step, this means an increment from 0x7FFF or below to 0x8000 or above, or a decrement from 0x8000 or above to 0x7FFF or below.
- R7: One clock after the offset update, the page output becomes the page presented at start, plus the carry flag on an increment, or minus one when carry is 0 on a decrement. The page wraps modulo 256, and the done pulse is high for that one cycle.
- R8: A start strobe sampled in the cycle where the page step takes place is ignored. It changes neither the offset nor the flags, and it raises no flag-write strobe.
- R9: Between operations the offset, page and flags hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one pointer step |
| dec_i | input | 1 | 1 = subtract step, 0 = add step |
| step_i | input | 4 | Unsigned step magnitude |
| page_i | input | 8 | Current page byte |
| ofs_i | input | 16 | Current offset in page |
| ofs_o | output | 16 | Updated offset |
| page_o | output | 8 | Updated page byte |
| flag_z_o | output | 1 | Zero flag of offset result |
| flag_n_o | output | 1 | Negative flag (offset bit 15) |
| flag_v_o | output | 1 | Signed overflow of offset operation |
| flag_c_o | output | 1 | Carry / no-borrow of offset operation |
| flag_we_o | output | 1 | Status register written this cycle |
| done_o | output | 1 | Page step finished this cycle |

## Verification
The assertions rely on the strobe discipline of the block itself: each accepted start yields a flag-write cycle followed by exactly one page-step cycle. They also assume outputs only move on those marked cycles, so they place no constraint on how often start is pulsed. The stimulus deliberately includes starts in the page-step cycle, back-to-back requests, a step of zero, and wrap points at both ends of the offset and page ranges. It always changes inputs on the falling edge, so every request is sampled cleanly on the next rising edge.

// File: rtl/ptr_step_pkg.sv
package ptr_step_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_PAGE = 1'b1
  } phase_t;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/ptr_ofs_alu.sv
module ptr_ofs_alu
  import ptr_step_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int STEP_W = 4
) (
  input  logic [OFS_W-1:0]  ofs_a,
  input  logic [STEP_W-1:0] step,
  input  logic              dec,
  output logic [OFS_W-1:0]  ofs_r,
  output flags_t            fl
);
  localparam int EXT = OFS_W - STEP_W;
  localparam int MSB = OFS_W - 1;

  logic [OFS_W-1:0] b_ext;
  logic [OFS_W-1:0] b_eff;
  logic [OFS_W:0]   sum;

  assign b_ext = {{EXT{1'b0}}, step};
  assign b_eff = dec ? ~b_ext : b_ext;

  // subtract as a + ~b + 1, so the carry out already means "no borrow"
  always_comb begin
    sum   = {1'b0, ofs_a} + {1'b0, b_eff} + {{OFS_W{1'b0}}, dec};
    ofs_r = sum[OFS_W-1:0];
    fl.c  = sum[OFS_W];
    fl.z  = (sum[OFS_W-1:0] == '0);
    fl.n  = sum[MSB];
    fl.v  = (ofs_a[MSB] == b_eff[MSB]) && (sum[MSB] != ofs_a[MSB]);
  end
endmodule

// File: rtl/ptr_page_step.sv
module ptr_page_step #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] page_a,
  input  logic              carry,
  input  logic              dec,
  output logic [PAGE_W-1:0] page_r
);
  logic [PAGE_W-1:0] delta;

  // inc: +carry ; dec: -1 when a borrow happened (carry clear)
  always_comb begin
    if (dec) delta = {PAGE_W{~carry}};
    else     delta = {{(PAGE_W-1){1'b0}}, carry};
    page_r = page_a + delta;
  end
endmodule

// File: rtl/ptr_step_ctrl.sv
module ptr_step_ctrl
  import ptr_step_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic page_go
);
  phase_t phase_q;

  assign load    = start && (phase_q == PH_IDLE);
  assign page_go = (phase_q == PH_PAGE);

  always_ff @(posedge clk) begin
    if (rst)       phase_q <= PH_IDLE;
    else if (load) phase_q <= PH_PAGE;
    else           phase_q <= PH_IDLE;
  end
endmodule

// File: rtl/ptr_step_unit.sv
module ptr_step_unit
  import ptr_step_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int PAGE_W = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              dec_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              flag_z_o,
  output logic              flag_n_o,
  output logic              flag_v_o,
  output logic              flag_c_o,
  output logic              flag_we_o,
  output logic              done_o
);
  logic              load, page_go;
  logic [OFS_W-1:0]  ofs_r;
  flags_t            fl_r;
  flags_t            flags_q;
  logic [PAGE_W-1:0] page_hold_q;
  logic              dec_hold_q;
  logic [PAGE_W-1:0] page_r;

  ptr_step_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start_i),
    .load    (load),
    .page_go (page_go)
  );

  ptr_ofs_alu #(.OFS_W(OFS_W), .STEP_W(STEP_W)) u_alu (
    .ofs_a (ofs_i),
    .step  (step_i),
    .dec   (dec_i),
    .ofs_r (ofs_r),
    .fl    (fl_r)
  );

  // page step consumes the carry from the registered status
  ptr_page_step #(.PAGE_W(PAGE_W)) u_page (
    .page_a (page_hold_q),
    .carry  (flags_q.c),
    .dec    (dec_hold_q),
    .page_r (page_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_o       <= '0;
      page_o      <= '0;
      flags_q     <= '0;
      page_hold_q <= '0;
      dec_hold_q  <= 1'b0;
      flag_we_o   <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      flag_we_o <= load;
      done_o    <= page_go;
      if (load) begin
        ofs_o       <= ofs_r;
        flags_q     <= fl_r;
        page_hold_q <= page_i;
        dec_hold_q  <= dec_i;
      end
      if (page_go) page_o <= page_r;
    end
  end

  assign flag_z_o = flags_q.z;
  assign flag_n_o = flags_q.n;
  assign flag_v_o = flags_q.v;
  assign flag_c_o = flags_q.c;
endmodule

// File: rtl/ptr_step_chk.sv
module ptr_step_chk #(
  parameter int OFS_W  = 16,
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [OFS_W-1:0]  ofs_o,
  input logic [PAGE_W-1:0] page_o,
  input logic              flag_z_o,
  input logic              flag_n_o,
  input logic              flag_v_o,
  input logic              flag_c_o,
  input logic              flag_we_o,
  input logic              done_o
);
  a_r2_we_single: assert property (@(posedge clk) disable iff (rst)
    flag_we_o |=> !flag_we_o);

  a_r7_done_follows_we: assert property (@(posedge clk) disable iff (rst)
    flag_we_o |=> done_o);

  a_r7_done_needs_we: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(flag_we_o));

  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flag_we_o, done_o}));

  a_r5_zero_flag: assert property (@(posedge clk) disable iff (rst)
    flag_we_o |-> (flag_z_o == (ofs_o == '0)));

  a_r5_neg_flag: assert property (@(posedge clk) disable iff (rst)
    flag_we_o |-> (flag_n_o == ofs_o[OFS_W-1]));

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !flag_we_o |-> $stable({flag_z_o, flag_n_o, flag_v_o, flag_c_o}));

  a_r9_ofs_hold: assert property (@(posedge clk) disable iff (rst)
    !flag_we_o |-> $stable(ofs_o));

  a_r7_page_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(page_o));
endmodule

bind ptr_step_unit ptr_step_chk #(.OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ofs_o     (ofs_o),
  .page_o    (page_o),
  .flag_z_o  (flag_z_o),
  .flag_n_o  (flag_n_o),
  .flag_v_o  (flag_v_o),
  .flag_c_o  (flag_c_o),
  .flag_we_o (flag_we_o),
  .done_o    (done_o)
);

// File: tb/sim_ptr_step_unit.sv
`timescale 1ns/1ps
module sim_ptr_step_unit;
  localparam int OFS_W  = 16;
  localparam int PAGE_W = 8;
  localparam int STEP_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic dec_i = 1'b0;
  logic [STEP_W-1:0] step_i = '0;
  logic [PAGE_W-1:0] page_i = '0;
  logic [OFS_W-1:0]  ofs_i = '0;
  logic [OFS_W-1:0]  ofs_o;
  logic [PAGE_W-1:0] page_o;
  logic flag_z_o, flag_n_o, flag_v_o, flag_c_o, flag_we_o, done_o;

  always #10 clk = ~clk;  // 50 MHz

  ptr_step_unit #(.OFS_W(OFS_W), .PAGE_W(PAGE_W), .STEP_W(STEP_W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .dec_i(dec_i), .step_i(step_i),
    .page_i(page_i), .ofs_i(ofs_i), .ofs_o(ofs_o), .page_o(page_o),
    .flag_z_o(flag_z_o), .flag_n_o(flag_n_o), .flag_v_o(flag_v_o),
    .flag_c_o(flag_c_o), .flag_we_o(flag_we_o), .done_o(done_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit cmp_en = 0;
  bit finished = 0;

  // behavioural reference model
  int m_ofs = 0, m_page = 0, m_hold_page = 0;
  int m_z = 0, m_n = 0, m_v = 0, m_c = 0, m_we = 0, m_done = 0;
  bit m_pend = 0, m_dec = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ofs = 0; m_page = 0; m_z = 0; m_n = 0; m_v = 0; m_c = 0;
      m_we = 0; m_done = 0; m_pend = 0;
    end else begin
      m_we = 0; m_done = 0;
      if (m_pend) begin
        if (m_dec) m_page = (m_hold_page + 256 - (m_c ? 0 : 1)) % 256;
        else       m_page = (m_hold_page + m_c) % 256;
        m_done = 1; m_pend = 0;
      end else if (start_i) begin
        int a, s, full;
        a = int'(ofs_i); s = int'(step_i);
        if (dec_i) begin
          full  = a - s;
          m_c   = (a >= s) ? 1 : 0;
          m_ofs = (full + 65536) % 65536;
          m_v   = (a >= 32768 && m_ofs < 32768) ? 1 : 0;
        end else begin
          full  = a + s;
          m_c   = (full >= 65536) ? 1 : 0;
          m_ofs = full % 65536;
          m_v   = (a < 32768 && m_ofs >= 32768) ? 1 : 0;
        end
        m_z = (m_ofs == 0) ? 1 : 0;
        m_n = (m_ofs >= 32768) ? 1 : 0;
        m_hold_page = int'(page_i);
        m_dec = dec_i;
        m_we = 1; m_pend = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      chk("R2/R3 offset", int'(ofs_o), m_ofs);
      chk("R7 page", int'(page_o), m_page);
      chk("R5 zero", int'(flag_z_o), m_z);
      chk("R5 negative", int'(flag_n_o), m_n);
      chk("R6 overflow", int'(flag_v_o), m_v);
      chk("R4 carry", int'(flag_c_o), m_c);
      chk("R2 flag write", int'(flag_we_o), m_we);
      chk("R7 done", int'(done_o), m_done);
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
    end
  end

  // directed step: checks offset/flags then page/done
  task automatic op_chk(input int pg, input int of, input int st, input bit dn,
                        input int e_ofs, input int e_pg, input int e_z,
                        input int e_n, input int e_v, input int e_c,
                        input string tag);
    @(negedge clk);
    start_i = 1; dec_i = dn; step_i = STEP_W'(st);
    page_i = PAGE_W'(pg); ofs_i = OFS_W'(of);
    @(negedge clk);
    start_i = 0;
    chk({tag, " R2/R3 ofs"}, int'(ofs_o), e_ofs);
    chk({tag, " R5 z"}, int'(flag_z_o), e_z);
    chk({tag, " R5 n"}, int'(flag_n_o), e_n);
    chk({tag, " R6 v"}, int'(flag_v_o), e_v);
    chk({tag, " R4 c"}, int'(flag_c_o), e_c);
    @(negedge clk);
    chk({tag, " R7 page"}, int'(page_o), e_pg);
    chk({tag, " R7 done"}, int'(done_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset ofs", int'(ofs_o), 0);
    chk("R1 reset page", int'(page_o), 0);
    chk("R1 reset flags", int'({flag_z_o, flag_n_o, flag_v_o, flag_c_o}), 0);
    chk("R1 reset strobes", int'({flag_we_o, done_o}), 0);
    rst = 0;
    @(negedge clk);
    cmp_en = 1;

    op_chk(8'h00, 16'hFFFF, 1, 0, 16'h0000, 8'h01, 1, 0, 0, 1, "inc wrap");
    op_chk(8'h01, 16'h0000, 1, 1, 16'hFFFF, 8'h00, 0, 1, 0, 0, "dec borrow");
    op_chk(8'h22, 16'h7FFF, 1, 0, 16'h8000, 8'h22, 0, 1, 1, 0, "inc ovf");
    op_chk(8'h22, 16'h8000, 2, 1, 16'h7FFE, 8'h22, 0, 0, 1, 1, "dec ovf");
    op_chk(8'hFF, 16'hFFF8, 9, 0, 16'h0001, 8'h00, 0, 0, 0, 1, "page wrap up");
    op_chk(8'h00, 16'h0003, 4, 1, 16'hFFFF, 8'hFF, 0, 1, 0, 0, "page wrap down");
    op_chk(8'h05, 16'h0010, 0, 1, 16'h0010, 8'h05, 0, 0, 0, 1, "step zero");

    // R8: start in page-step cycle is ignored
    @(negedge clk);
    start_i = 1; dec_i = 0; step_i = 4'd3; page_i = 8'h40; ofs_i = 16'h1000;
    @(negedge clk);
    ofs_i = 16'h5555; step_i = 4'd7; dec_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R8 busy ofs", int'(ofs_o), 16'h1003);
    chk("R8 busy we", int'(flag_we_o), 0);
    // R9: state holds while idle
    repeat (4) @(negedge clk);
    chk("R9 hold ofs", int'(ofs_o), 16'h1003);
    chk("R9 hold page", int'(page_o), 8'h40);

    // random traffic, including back-to-back and busy-cycle starts
    for (int i = 0; i < 2000; i++) begin
      int gap;
      @(negedge clk);
      start_i = 1;
      dec_i = $urandom_range(1, 0) == 1;
      step_i = STEP_W'($urandom_range(15, 0));
      page_i = PAGE_W'($urandom_range(255, 0));
      case ($urandom_range(3, 0))
        0: ofs_i = OFS_W'($urandom_range(15, 0));
        1: ofs_i = OFS_W'(16'hFFF0 + $urandom_range(15, 0));
        2: ofs_i = OFS_W'(16'h7FF8 + $urandom_range(15, 0));
        default: ofs_i = OFS_W'($urandom_range(65535, 0));
      endcase
      @(negedge clk);
      start_i = 0;
      gap = $urandom_range(3, 0);
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    summary();
  end
endmodule